// File: doc/BRIEF.md
# Overcurrent and Brownout Fault Supervisor

This block is the digital fault supervisor of an off-line flyback switcher. It receives comparator decisions from the analog front end: a hard overcurrent flag that is set when the sensed switch current passes a level above the normal peak limit, and a brownout flag that is set when the demagnetization pin sources too little current during the on-time. It also receives four supply-level flags (turn-on, top-up, undervoltage lockout and deep-discharge floor). A cycle-end strobe marks the moment at which the per-cycle fault flags are valid. From these inputs it drives the power switch enable, the high-voltage start-up current generator enable and a two-bit fault status.

A single overcurrent event only sets a warning. The warning clears if the next strobed cycle is clean, so noise from ESD or similar disturbances is not treated as a fault. When the overcurrent flag is seen on `STRIKES` strobes in a row, or the brownout flag is seen on any strobe, switching stops and the stop is latched. The latch lets go only when the supply decays below the lockout level. The start-up generator then stays off until the supply sinks below the floor, after which it recharges to the turn-on level and switching resumes. Repeated faults therefore give a slow hiccup. With no fault present, the generator tops up the supply whenever it drops below the top-up level, and a supply below lockout stops switching and starts a normal recharge.

The supply sequencer has six states: CHARGE (normal charge), RUN, TOPUP, HALT (latched fault), DRAIN (decay after a fault) and REFILL (charge after a fault). Its transitions are:
- CHARGE goes to RUN on turn-on.
- RUN goes to TOPUP below the top-up level, to CHARGE below lockout and to HALT on a confirmed trip.
- TOPUP goes to RUN on turn-on, to CHARGE below lockout and to HALT on a trip.
- HALT goes to DRAIN below lockout.
- DRAIN goes to REFILL below the floor.
- REFILL goes to RUN on turn-on.

The strike filter has two states, IDLE and WARN, together with a count of consecutive strikes.

Top module: `fault_supervisor`

## Requirements
- R1: While reset is held and in the first cycle after it, the block is in a normal charge: sw_en=0, hv_en=1, fault_status=0 (0 idle, 1 warning, 2 latched, 3 recovering).
- R2: From a normal charge, the first clock edge that sees vcc_ge_on=1 makes sw_en=1 and hv_en=0 in the next cycle.
- R3: While switching, vcc_ge_topup=0 (with vcc_ge_uvlo=1) sets hv_en=1 with sw_en still 1. A later vcc_ge_on=1 clears hv_en.
- R4: While switching with no confirmed fault, vcc_ge_uvlo=0 makes sw_en=0 and hv_en=1 in the next cycle, and fault_status stays 0.
- R5: While switching, a strobe (cyc_end=1) with oc_trip=1 that is not the STRIKES-th in a row sets fault_status=1 and switching continues.
- R6: A warning is kept through cycles without a strobe and is cleared to fault_status=0 by the next strobe with oc_trip=0 and bo_low=0.
- R7: oc_trip=1 on STRIKES consecutive strobes while switching makes sw_en=0, hv_en=0 and fault_status=2 in the next cycle.
- R8: Once latched, the state does not change while vcc_ge_uvlo=1, whatever the values of vcc_ge_on, vcc_ge_topup, oc_trip, bo_low and cyc_end.
- R9: From the latched state, vcc_ge_uvlo=0 gives fault_status=3 with hv_en=0. hv_en stays 0 until vcc_ge_floor=0, after which hv_en=1 with fault_status=3.
- R10: When recharging after a fault, vcc_ge_on=1 resumes switching (sw_en=1, hv_en=0) with fault_status=0.
- R11: While switching, a strobe with bo_low=1 latches the fault at once (fault_status=2, sw_en=0) without a warning step.
- R12: oc_trip and bo_low have no effect in cycles without a strobe and in any cycle where the switch is not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_end | input | 1 | Switching-cycle end strobe; fault flags are valid in this cycle |
| oc_trip | input | 1 | Hard overcurrent comparator result for the current cycle |
| bo_low | input | 1 | Demagnetization-pin source current was too low during on-time |
| vcc_ge_on | input | 1 | Supply at or above the turn-on level |
| vcc_ge_topup | input | 1 | Supply at or above the top-up level |
| vcc_ge_uvlo | input | 1 | Supply at or above the lockout level |
| vcc_ge_floor | input | 1 | Supply at or above the deep-discharge floor |
| sw_en | output | 1 | Power switch enable |
| hv_en | output | 1 | Start-up current generator enable |
| fault_status | output | 2 | 0 idle, 1 warning, 2 latched, 3 recovering |

## Verification
The bench builds the block with STRIKES=2. With that value one clean strobe between two overcurrent strobes is enough to tell a cleared warning from a confirmed fault, and a full hiccup round (latch, decay, floor, refill, restart) fits in a handful of cycles. The supply flags come from a single randomly walking level, so they stay mutually consistent while every sequencer state and every transition is visited many times. Overcurrent and brownout flags arrive in every state, both on and off the strobe, which exercises the case where a pending warning meets lockout and the case where a fault flag arrives while the switch is off.

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;

    typedef enum logic [2:0] {
        PWR_CHARGE = 3'd0,
        PWR_RUN    = 3'd1,
        PWR_TOPUP  = 3'd2,
        PWR_HALT   = 3'd3,
        PWR_DRAIN  = 3'd4,
        PWR_REFILL = 3'd5
    } pwr_state_t;

    typedef enum logic {
        FLT_IDLE = 1'b0,
        FLT_WARN = 1'b1
    } flt_state_t;

    typedef enum logic [1:0] {
        STAT_IDLE  = 2'd0,
        STAT_WARN  = 2'd1,
        STAT_LATCH = 2'd2,
        STAT_RECHG = 2'd3
    } fault_stat_t;

    typedef struct packed {
        logic on;
        logic topup;
        logic uvlo;
        logic floor;
    } supply_flags_t;

endpackage

// File: rtl/strike_filter.sv
module strike_filter
    import fault_sup_pkg::*;
#(
    parameter int STRIKES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic cyc_end,
    input  logic oc_trip,
    input  logic bo_low,
    output logic warn,
    output logic trip
);

    localparam int CW = $clog2(STRIKES + 1);
    localparam logic [CW-1:0] LAST = CW'(STRIKES - 1);

    flt_state_t     st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        trip  = armed && cyc_end && (bo_low || (oc_trip && (cnt_q == LAST)));
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!armed || trip) begin
            st_d  = FLT_IDLE;
            cnt_d = '0;
        end else if (cyc_end) begin
            unique case (st_q)
                FLT_IDLE: begin
                    if (oc_trip) begin
                        st_d  = FLT_WARN;
                        cnt_d = CW'(1);
                    end
                end
                FLT_WARN: begin
                    if (oc_trip) begin
                        cnt_d = cnt_q + CW'(1);
                    end else begin
                        st_d  = FLT_IDLE;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = FLT_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_comb begin
        warn = (st_q == FLT_WARN);
    end

    // R6
    clean_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cyc_end && !oc_trip && !bo_low |=> !warn);

    // R6
    warn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !cyc_end && warn |=> warn);

    // R12
    disarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !warn);

    generate
        if (STRIKES > 1) begin : g_multi
            // R5
            first_strike_chk: assert property (@(posedge clk) disable iff (!rst_n)
                armed && cyc_end && !warn && oc_trip && !bo_low |-> !trip ##1 warn);
        end
    endgenerate

endmodule

// File: rtl/supply_sequencer.sv
module supply_sequencer
    import fault_sup_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trip,
    input  supply_flags_t sup,
    output logic          sw_en,
    output logic          hv_en,
    output logic          latched,
    output logic          recovering
);

    pwr_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PWR_CHARGE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PWR_CHARGE: begin
                if (sup.on) st_d = PWR_RUN;
            end
            PWR_RUN: begin
                if (trip)            st_d = PWR_HALT;
                else if (!sup.uvlo)  st_d = PWR_CHARGE;
                else if (!sup.topup) st_d = PWR_TOPUP;
            end
            PWR_TOPUP: begin
                if (trip)           st_d = PWR_HALT;
                else if (!sup.uvlo) st_d = PWR_CHARGE;
                else if (sup.on)    st_d = PWR_RUN;
            end
            PWR_HALT: begin
                if (!sup.uvlo) st_d = PWR_DRAIN;
            end
            PWR_DRAIN: begin
                if (!sup.floor) st_d = PWR_REFILL;
            end
            PWR_REFILL: begin
                if (sup.on) st_d = PWR_RUN;
            end
            default: st_d = PWR_CHARGE;
        endcase
    end

    always_comb begin
        sw_en      = (st_q == PWR_RUN) || (st_q == PWR_TOPUP);
        hv_en      = (st_q == PWR_CHARGE) || (st_q == PWR_TOPUP) || (st_q == PWR_REFILL);
        latched    = (st_q == PWR_HALT);
        recovering = (st_q == PWR_DRAIN) || (st_q == PWR_REFILL);
    end

    // R7
    trip_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (st_q == PWR_HALT));

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PWR_HALT) && sup.uvlo |=> (st_q == PWR_HALT));

    // R9
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PWR_DRAIN) && sup.floor |=> (st_q == PWR_DRAIN) && !hv_en);

    // R4
    uvlo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en && !trip && !sup.uvlo |=> !sw_en && hv_en);

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PWR_CHARGE) && sup.on |=> sw_en && !hv_en);

    // R10
    refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PWR_REFILL) && sup.on |=> sw_en && !recovering);

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fault_sup_pkg::*;
#(
    parameter int STRIKES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_end,
    input  logic       oc_trip,
    input  logic       bo_low,
    input  logic       vcc_ge_on,
    input  logic       vcc_ge_topup,
    input  logic       vcc_ge_uvlo,
    input  logic       vcc_ge_floor,
    output logic       sw_en,
    output logic       hv_en,
    output logic [1:0] fault_status
);

    supply_flags_t sup;
    logic          warn, trip, latched, recovering;
    fault_stat_t   stat;

    always_comb begin
        sup.on    = vcc_ge_on;
        sup.topup = vcc_ge_topup;
        sup.uvlo  = vcc_ge_uvlo;
        sup.floor = vcc_ge_floor;
    end

    strike_filter #(.STRIKES(STRIKES)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .armed   (sw_en),
        .cyc_end (cyc_end),
        .oc_trip (oc_trip),
        .bo_low  (bo_low),
        .warn    (warn),
        .trip    (trip)
    );

    supply_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trip       (trip),
        .sup        (sup),
        .sw_en      (sw_en),
        .hv_en      (hv_en),
        .latched    (latched),
        .recovering (recovering)
    );

    always_comb begin
        if (latched)         stat = STAT_LATCH;
        else if (recovering) stat = STAT_RECHG;
        else if (warn)       stat = STAT_WARN;
        else                 stat = STAT_IDLE;
        fault_status = stat;
    end

    // R11
    brownout_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_en && cyc_end && bo_low |=> (fault_status == 2'd2) && !sw_en);

    // R7
    latched_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status == 2'd2) |-> !sw_en && !hv_en);

endmodule

// File: tb/fault_supervisor_bench.sv
module fault_supervisor_bench;

    localparam int STRIKES = 2;
    localparam int M_CHG = 0, M_RUN = 1, M_TOP = 2, M_HALT = 3, M_DRN = 4, M_REF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_end = 1'b0, oc_trip = 1'b0, bo_low = 1'b0;
    int   lv = 0;
    logic sw_en, hv_en;
    logic [1:0] fault_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_st = M_CHG;
    int m_cnt = 0;

    always #10 clk = ~clk;

    fault_supervisor #(.STRIKES(STRIKES)) u_fault_supervisor (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_end      (cyc_end),
        .oc_trip      (oc_trip),
        .bo_low       (bo_low),
        .vcc_ge_on    (lv >= 4),
        .vcc_ge_topup (lv >= 3),
        .vcc_ge_uvlo  (lv >= 2),
        .vcc_ge_floor (lv >= 1),
        .sw_en        (sw_en),
        .hv_en        (hv_en),
        .fault_status (fault_status)
    );

    function automatic bit exp_sw(int s);
        return (s == M_RUN) || (s == M_TOP);
    endfunction

    function automatic bit exp_hv(int s);
        return (s == M_CHG) || (s == M_TOP) || (s == M_REF);
    endfunction

    function automatic int exp_stat(int s, int c);
        if (s == M_HALT) return 2;
        if (s == M_DRN || s == M_REF) return 3;
        if (c > 0) return 1;
        return 0;
    endfunction

    function automatic string tag_of(int s, int c);
        if (c > 0) return "R5";
        case (s)
            M_RUN:   return "R2";
            M_TOP:   return "R3";
            M_CHG:   return "R4";
            M_HALT:  return "R8";
            M_DRN:   return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic model_step();
        bit armed, trp;
        int nx;
        armed = (m_st == M_RUN) || (m_st == M_TOP);
        trp = armed && cyc_end && (bo_low || (oc_trip && m_cnt == STRIKES - 1));
        nx = m_st;
        case (m_st)
            M_CHG:  if (lv >= 4) nx = M_RUN;
            M_RUN:  if (trp) nx = M_HALT; else if (lv < 2) nx = M_CHG; else if (lv < 3) nx = M_TOP;
            M_TOP:  if (trp) nx = M_HALT; else if (lv < 2) nx = M_CHG; else if (lv >= 4) nx = M_RUN;
            M_HALT: if (lv < 2) nx = M_DRN;
            M_DRN:  if (lv < 1) nx = M_REF;
            default: if (lv >= 4) nx = M_RUN;
        endcase
        if (!armed || trp) m_cnt = 0;
        else if (cyc_end) m_cnt = oc_trip ? m_cnt + 1 : 0;
        m_st = nx;
    endtask

    task automatic cyc(int l, bit c, bit o, bit b);
        lv = l; cyc_end = c; oc_trip = o; bo_low = b;
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic expect_out(string tag, bit s, bit h, int st);
        checks++;
        if (sw_en !== s || hv_en !== h || int'(fault_status) != st) begin
            errors++;
            $display("FAIL %s: sw_en=%0b hv_en=%0b status=%0d expected sw_en=%0b hv_en=%0b status=%0d",
                     tag, sw_en, hv_en, fault_status, s, h, st);
        end
    endtask

    task automatic check_model();
        expect_out(tag_of(m_st, m_cnt), exp_sw(m_st), exp_hv(m_st), exp_stat(m_st, m_cnt));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24680));
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b0, 1'b1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after reset", 1'b0, 1'b1, 0);

        cyc(4, 0, 0, 0); expect_out("R2 start", 1'b1, 1'b0, 0);
        cyc(3, 0, 0, 0); expect_out("R2 hold run", 1'b1, 1'b0, 0);
        cyc(2, 0, 0, 0); expect_out("R3 topup on", 1'b1, 1'b1, 0);
        cyc(4, 0, 0, 0); expect_out("R3 topup off", 1'b1, 1'b0, 0);
        cyc(1, 0, 0, 0); expect_out("R4 uvlo stop", 1'b0, 1'b1, 0);
        cyc(4, 0, 0, 0); expect_out("R2 restart", 1'b1, 1'b0, 0);
        cyc(4, 1, 1, 0); expect_out("R5 warning", 1'b1, 1'b0, 1);
        cyc(4, 0, 1, 1); expect_out("R12 no strobe", 1'b1, 1'b0, 1);
        cyc(4, 0, 0, 0); expect_out("R6 warning held", 1'b1, 1'b0, 1);
        cyc(4, 1, 0, 0); expect_out("R6 clean clear", 1'b1, 1'b0, 0);
        cyc(4, 1, 1, 0); expect_out("R5 second warning", 1'b1, 1'b0, 1);
        cyc(4, 1, 1, 0); expect_out("R7 confirm", 1'b0, 1'b0, 2);
        cyc(4, 1, 1, 1); expect_out("R8 hold high", 1'b0, 1'b0, 2);
        cyc(2, 1, 0, 0); expect_out("R8 hold uvlo edge", 1'b0, 1'b0, 2);
        cyc(1, 0, 0, 0); expect_out("R9 drain", 1'b0, 1'b0, 3);
        cyc(3, 0, 0, 0); expect_out("R9 no recharge", 1'b0, 1'b0, 3);
        cyc(0, 0, 0, 0); expect_out("R9 refill", 1'b0, 1'b1, 3);
        cyc(3, 1, 1, 1); expect_out("R12 off ignore", 1'b0, 1'b1, 3);
        cyc(4, 0, 0, 0); expect_out("R10 resume", 1'b1, 1'b0, 0);
        cyc(4, 1, 0, 1); expect_out("R11 brownout", 1'b0, 1'b0, 2);
        cyc(1, 0, 0, 0); expect_out("R9 drain again", 1'b0, 1'b0, 3);
        cyc(0, 0, 0, 0); expect_out("R9 refill again", 1'b0, 1'b1, 3);
        cyc(4, 0, 0, 0); expect_out("R10 resume again", 1'b1, 1'b0, 0);
        cyc(4, 1, 1, 0); expect_out("R5 warn before uvlo", 1'b1, 1'b0, 1);
        cyc(1, 1, 1, 0); expect_out("R7 confirm beats uvlo", 1'b0, 1'b0, 2);

        for (int i = 0; i < 4000; i++) begin
            int nl;
            nl = lv;
            if ($urandom % 6 == 0) begin
                if ($urandom % 2 == 0) nl = (lv < 4) ? lv + 1 : 4;
                else                   nl = (lv > 0) ? lv - 1 : 0;
            end
            cyc(nl, ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 40) == 0);
            check_model();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule